// File: doc/BRIEF.md
# Master Clock Ratio Detector

The detector takes a master clock and a frame clock that runs at the sample rate. Both are frequency-locked, but their phase can be anything. It counts master-clock cycles between successive rising edges of the frame clock and reads the count as a ratio of 256, 384 or 512 times the sample rate. Only the ratio matters, so 32, 44.1 and 48 kHz systems behave the same way.

From the detected ratio it produces a single-cycle enable at a steady 256 times the sample rate:

- at 256fs it fires on every cycle;
- at 384fs it fires on two of every three cycles;
- at 512fs it fires on every other cycle.

The rest of the codec's digital logic uses this enable as its internal master rate. The detector also reports a lock flag and a mute request. Downstream datapaths force their samples to zero on the mute request, so that changing the clock relationship causes no audible click.

Top module: `mclk_ratio_det`

## Requirements
- R1: A frame period of 256, 384 or 512 master cycles, each within ±TOL (default 2), is classified as code 0, 1 or 2 respectively on `ratio_o`. A period of 258 is therefore taken as code 0.
- R2: A frame period outside every tolerance window (for example 259) clears `locked_o` two master edges after the frame rise that ends it, and `ratio_o` keeps its last value.
- R3: `locked_o` rises only after two consecutive measured periods give the same legal code, two edges after the second of them. `ratio_o` takes that code at the same edge and stays stable while locked.
- R4: A measured period whose legal code differs from the locked one clears `locked_o` at once, two edges after its ending rise.
- R5: If no frame rise arrives for TIMEOUT (default 1024) master cycles, `locked_o` falls. Lock is held for any gap shorter than that.
- R6: `mute_o` is high whenever `locked_o` is low. After lock is gained it also stays high for the whole next frame, and clears at the following measurement.
- R7: While locked to a steady ratio, `en256_o` fires exactly 256 times per frame period. Its pattern is every cycle for code 0, two of three cycles for code 1 and every other cycle for code 2, with the phase restarted at each frame rise.
- R8: After reset, `locked_o`=0, `mute_o`=1, `ratio_o`=0 and `en256_o`=0.
- R9: The first frame rise after reset or after a timeout only sets a reference and yields no measurement. Relock therefore needs three rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame clock, sampled on the master clock |
| en256_o | output | 1 | Single-cycle enable at 256 times the sample rate |
| ratio_o | output | 2 | Detected ratio code: 0=256, 1=384, 2=512 |
| locked_o | output | 1 | Ratio detected and stable |
| mute_o | output | 1 | Request to zero downstream samples |

## Verification
A frame rise is seen at the edge where `frame_i` is first sampled high. The measurement is registered one edge later, and lock, ratio and mute change on the edge after that. The enable is registered, so its frame window is the edge of the rise through the next P-1 edges. The bench changes `frame_i` only at falling edges. It checks lock, ratio and mute at the falling edge that ends a frame sequence, which is far more than two edges after the last rise. It counts enables over exactly one frame of falling-edge samples, starting right after the rise edge. The timeout checks sample 956 cycles after a rise, where lock must hold, and 1056 cycles after it, where lock must be gone.

// File: rtl/mclk_ratio_det_pkg.sv
package mclk_ratio_det_pkg;
  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2
  } ratio_e;

  localparam int NUM_RATIOS = 3;

  // nominal period in master cycles for ratio index i, given the base count
  function automatic int ratio_period(input int base, input int idx);
    return (base * (idx + 2)) / 2;
  endfunction
endpackage

// File: rtl/crd_period_meter.sv
module crd_period_meter
  import mclk_ratio_det_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int TOL     = 2,
  parameter int TIMEOUT = 1024,
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_i,
  output logic   rise_o,
  output logic   stall_o,
  output logic   meas_vld_o,
  output logic   meas_ok_o,
  output ratio_e meas_code_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT);

  logic          frm_q;
  logic          have_ref_q;
  logic [CW-1:0] cnt_q;
  logic [NUM_RATIOS-1:0] hit;
  logic          ok_d;
  ratio_e        code_d;

  assign rise_o  = frame_i & ~frm_q;
  assign stall_o = (cnt_q == CNT_MAX) & ~rise_o;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int TGT = ratio_period(BASE, i);
    assign hit[i] = (int'(cnt_q) + TOL >= TGT) && (int'(cnt_q) <= TGT + TOL);
  end

  always_comb begin
    ok_d   = 1'b1;
    code_d = RATIO_256;
    unique casez (hit)
      3'b??1:  code_d = RATIO_256;
      3'b?10:  code_d = RATIO_384;
      3'b100:  code_d = RATIO_512;
      default: ok_d   = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q       <= 1'b0;
      have_ref_q  <= 1'b0;
      cnt_q       <= '0;
      meas_vld_o  <= 1'b0;
      meas_ok_o   <= 1'b0;
      meas_code_o <= RATIO_256;
    end else begin
      frm_q      <= frame_i;
      meas_vld_o <= rise_o & have_ref_q;
      if (rise_o) begin
        cnt_q       <= CW'(1);
        meas_ok_o   <= ok_d;
        meas_code_o <= code_d;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (stall_o)     have_ref_q <= 1'b0;
      else if (rise_o) have_ref_q <= 1'b1;
    end
  end
endmodule

// File: rtl/crd_lock_ctrl.sv
module crd_lock_ctrl
  import mclk_ratio_det_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stall_i,
  input  logic   meas_vld_i,
  input  logic   meas_ok_i,
  input  ratio_e meas_code_i,
  output logic   locked_o,
  output ratio_e ratio_o,
  output logic   mute_o
);
  ratio_e cand_q;
  logic   cand_vld_q;
  logic   grace_q;

  assign mute_o = ~locked_o | grace_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q     <= RATIO_256;
      cand_vld_q <= 1'b0;
      locked_o   <= 1'b0;
      grace_q    <= 1'b0;
      ratio_o    <= RATIO_256;
    end else if (stall_i) begin
      cand_vld_q <= 1'b0;
      locked_o   <= 1'b0;
      grace_q    <= 1'b0;
    end else if (meas_vld_i) begin
      grace_q <= 1'b0;
      if (!meas_ok_i) begin
        cand_vld_q <= 1'b0;
        locked_o   <= 1'b0;
      end else if (cand_vld_q && meas_code_i == cand_q) begin
        if (!locked_o) begin
          locked_o <= 1'b1;
          grace_q  <= 1'b1;   // mute one more frame after relock
          ratio_o  <= meas_code_i;
        end
      end else begin
        cand_q     <= meas_code_i;
        cand_vld_q <= 1'b1;
        locked_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crd_rate_gen.sv
module crd_rate_gen
  import mclk_ratio_det_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rise_i,
  input  ratio_e ratio_i,
  output logic   en_o
);
  logic [1:0] ph_q, ph_cur, ph_nxt;
  logic       fire;

  assign ph_cur = rise_i ? 2'd0 : ph_q;

  always_comb begin
    unique case (ratio_i)
      RATIO_384: begin
        fire   = (ph_cur != 2'd2);
        ph_nxt = (ph_cur == 2'd2) ? 2'd0 : ph_cur + 2'd1;
      end
      RATIO_512: begin
        fire   = (ph_cur == 2'd0);
        ph_nxt = (ph_cur == 2'd0) ? 2'd1 : 2'd0;
      end
      default: begin
        fire   = 1'b1;
        ph_nxt = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 2'd0;
      en_o <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      en_o <= fire;
    end
  end
endmodule

// File: rtl/mclk_ratio_det.sv
module mclk_ratio_det
  import mclk_ratio_det_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int TOL     = 2,
  parameter int TIMEOUT = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  output logic       en256_o,
  output logic [1:0] ratio_o,
  output logic       locked_o,
  output logic       mute_o
);
  logic   rise, stall, meas_vld, meas_ok;
  ratio_e meas_code, ratio;

  crd_period_meter #(.BASE(BASE), .TOL(TOL), .TIMEOUT(TIMEOUT)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .rise_o     (rise),
    .stall_o    (stall),
    .meas_vld_o (meas_vld),
    .meas_ok_o  (meas_ok),
    .meas_code_o(meas_code)
  );

  crd_lock_ctrl u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall),
    .meas_vld_i (meas_vld),
    .meas_ok_i  (meas_ok),
    .meas_code_i(meas_code),
    .locked_o   (locked_o),
    .ratio_o    (ratio),
    .mute_o     (mute_o)
  );

  crd_rate_gen u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .ratio_i(ratio),
    .en_o   (en256_o)
  );

  assign ratio_o = ratio;
endmodule

// File: rtl/mclk_ratio_det_chk.sv
module mclk_ratio_det_chk #(
  parameter int TIMEOUT = 1024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       en256_o,
  input logic [1:0] ratio_o,
  input logic       locked_o,
  input logic       mute_o
);
  localparam int CW = $clog2(TIMEOUT + 3);
  localparam logic [CW-1:0] GAP_LIM = CW'(TIMEOUT + 2);

  logic          frm_q;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q <= 1'b0;
      gap_q <= '0;
    end else begin
      frm_q <= frame_i;
      if (frame_i && !frm_q)   gap_q <= '0;
      else if (gap_q != GAP_LIM) gap_q <= gap_q + CW'(1);
    end
  end

  a_r6_mute_when_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> mute_o);

  a_r6_mute_on_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> mute_o);

  a_r3_ratio_stable_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(ratio_o));

  a_r1_ratio_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o != 2'd3);

  a_r5_timeout_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q > CW'(TIMEOUT)) |-> !locked_o);

  a_r7_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o) && ratio_o == 2'd0 && $past(ratio_o) == 2'd0) |-> en256_o);
endmodule

bind mclk_ratio_det mclk_ratio_det_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .en256_o (en256_o),
  .ratio_o (ratio_o),
  .locked_o(locked_o),
  .mute_o  (mute_o)
);

// File: tb/sim_mclk_ratio_det.sv
module sim_mclk_ratio_det;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       en256_o;
  logic [1:0] ratio_o;
  logic       locked_o, mute_o;

  int n_chk = 0, n_bad = 0;
  int en_cnt;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mclk_ratio_det u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
    .en256_o(en256_o), .ratio_o(ratio_o), .locked_o(locked_o), .mute_o(mute_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n frames of p cycles; en256 counted over the last frame
  task automatic run_frames(input int p, input int n);
    for (int f = 0; f < n; f++) begin
      en_cnt = 0;
      for (int i = 0; i < p; i++) begin
        frame_i = (i < p / 2);
        @(posedge clk_i);
        @(negedge clk_i);
        en_cnt += int'(en256_o);
      end
    end
  endtask

  task automatic idle(input int n);
    frame_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R8 locked", int'(locked_o), 0);
    chk("R8 mute", int'(mute_o), 1);
    chk("R8 ratio", int'(ratio_o), 0);
    chk("R8 en", int'(en256_o), 0);
  endtask

  task automatic t_256;
    run_frames(256, 2);
    chk("R9 no lock after two rises", int'(locked_o), 0);
    run_frames(256, 1);
    chk("R3 locked 256", int'(locked_o), 1);
    chk("R1 code 256", int'(ratio_o), 0);
    chk("R6 grace mute", int'(mute_o), 1);
    run_frames(256, 1);
    chk("R6 mute cleared", int'(mute_o), 0);
    chk("R7 enables 256fs", en_cnt, 256);
  endtask

  task automatic t_switch(input int p, input int code, input string nm);
    run_frames(p, 2);
    chk({"R4 drop on change ", nm}, int'(locked_o), 0);
    chk({"R6 mute on change ", nm}, int'(mute_o), 1);
    run_frames(p, 1);
    chk({"R3 relock ", nm}, int'(locked_o), 1);
    chk({"R1 code ", nm}, int'(ratio_o), code);
    run_frames(p, 1);
    chk({"R6 unmute ", nm}, int'(mute_o), 0);
    chk({"R7 enables ", nm}, en_cnt, 256);
  endtask

  task automatic t_tol;
    run_frames(258, 3);
    chk("R1 258 taken as 256", int'(ratio_o), 0);
    chk("R1 258 locked", int'(locked_o), 1);
    run_frames(259, 2);
    chk("R2 259 rejected", int'(locked_o), 0);
    chk("R2 ratio held", int'(ratio_o), 0);
    chk("R2 mute", int'(mute_o), 1);
  endtask

  task automatic t_stall;
    run_frames(256, 4);
    chk("R3 relock after reject", int'(locked_o), 1);
    idle(700);   // 956 cycles since last rise
    chk("R5 lock held below timeout", int'(locked_o), 1);
    idle(100);   // 1056 cycles since last rise
    chk("R5 timeout unlock", int'(locked_o), 0);
    chk("R5 mute", int'(mute_o), 1);
    run_frames(256, 2);
    chk("R9 reference after timeout", int'(locked_o), 0);
    run_frames(256, 1);
    chk("R9 relock third rise", int'(locked_o), 1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #100000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_256();
    t_switch(384, 1, "384");
    t_switch(512, 2, "512");
    t_tol();
    t_stall();
    done = 1;
    finish_run();
  end
endmodule